// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM read or write burst. A controller presents a starting column, the burst-length code and the ordering bit from its programmed mode word, the write-single-location option, and whether the access is a write. It then pulses a start strobe. Starting on the next cycle, the generator steps through one column per clock. It keeps each finite burst inside the naturally aligned block of that length. It flags the final beat, and in full-page mode it keeps wrapping around the row until a terminate strobe arrives.

Mode words that the generator cannot honour raise an error flag and produce no beats. A new start during a running burst abandons the old sequence and begins the new one, which is how a burst interrupt looks from here.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, valid_o, last_o and err_o are all low.
- R2: When start_i is sampled high with a legal mode, the first beat appears on the next cycle with col_o equal to col_i. The burst then advances exactly one beat per clock.
- R3: With ordering bit 0 (sequential) and length code 001 (2), 010 (4) or 011 (8), the column bits above the length stay those of col_i. The low bits count up from the start and wrap to the first column of the aligned block.
- R4: With ordering bit 1 (interleaved) and length 4 or 8, the low bits of beat k equal the start's low bits XOR k. For example, start 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: last_o is high on the final beat of a finite burst only. valid_o is low on the cycle after that beat unless a new start was sampled.
- R6: Length code 000 gives one beat with last_o high, and the ordering bit is ignored.
- R7: Length code 111 (full page, sequential only) steps through col_i, col_i+1, ... modulo 256 with no last_o. It runs past 256 beats until term_i is sampled high, and valid_o is low from the next cycle.
- R8: When wr_single_i and is_write_i are both high at start, the burst is one beat with last_o high. A read with the same mode word uses the programmed length.
- R9: Length codes 100, 101 and 110, and the ordering bit set with code 001 or 111, set err_o from the next cycle and produce no beats. The next legal start clears err_o.
- R10: A start sampled during an active burst restarts from the new col_i and mode. Start takes priority over a terminate sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a burst with the inputs below |
| term_i | input | 1 | Stop the active burst |
| is_write_i | input | 1 | The access being started is a write |
| col_i | input | 8 | Starting column |
| blen_i | input | 3 | Burst-length code |
| btype_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| wr_single_i | input | 1 | Writes use a single location |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Current beat is the final one |
| err_o | output | 1 | Last start carried an unusable mode |

## Verification
Every output is a function of state registered on the start edge, so beat 0 and err_o are due one cycle after the edge that samples start_i. Beat k is due k cycles later, and valid_o falls one cycle after the last beat or after the terminate edge. The bench drives inputs and samples outputs on the falling edge. After a start it reads beat 0 at the next falling edge and one beat at each falling edge after that, so every comparison is made one register stage after its cause.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam logic [2:0] BL_ONE  = 3'b000;
  localparam logic [2:0] BL_TWO  = 3'b001;
  localparam logic [2:0] BL_FOUR = 3'b010;
  localparam logic [2:0] BL_EIGHT = 3'b011;
  localparam logic [2:0] BL_PAGE = 3'b111;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
endpackage

// File: rtl/colgen_decode.sv
module colgen_decode
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       blen_i,
  input  logic             btype_i,
  input  logic             single_i,
  output logic             legal_o,
  output logic             page_o,
  output order_e           ord_o,
  output logic [COL_W-1:0] mask_o
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic [COL_W-1:0] raw_mask;
  logic             raw_page;
  logic             code_ok;

  always_comb begin
    raw_mask = '0;
    raw_page = 1'b0;
    code_ok  = 1'b1;
    unique case (blen_i)
      BL_ONE:   raw_mask = '0;
      BL_TWO:   raw_mask = COL_W'(1);
      BL_FOUR:  raw_mask = COL_W'(3);
      BL_EIGHT: raw_mask = COL_W'(7);
      BL_PAGE: begin
        raw_mask = ALL_ONES;
        raw_page = 1'b1;
      end
      default:  code_ok = 1'b0;
    endcase
  end

  // interleave only legal for 4 and 8; ignored for length 1
  assign legal_o = code_ok &&
                   !(btype_i && (blen_i == BL_TWO || blen_i == BL_PAGE));
  assign mask_o  = single_i ? '0 : raw_mask;
  assign page_o  = single_i ? 1'b0 : raw_page;
  assign ord_o   = (btype_i && mask_o != '0) ? ORD_ILV : ORD_SEQ;
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             legal_i,
  input  logic             page_i,
  input  order_e           ord_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic [COL_W-1:0] col_i,
  output logic             active_o,
  output logic             last_o,
  output logic             err_o,
  output logic             page_o,
  output order_e           ord_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o
);
  assign last_o = active_o && !page_o && (beat_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      err_o    <= 1'b0;
      page_o   <= 1'b0;
      ord_o    <= ORD_SEQ;
      base_o   <= '0;
      beat_o   <= '0;
      mask_o   <= '0;
    end else if (start_i) begin
      active_o <= legal_i;
      err_o    <= !legal_i;
      page_o   <= page_i;
      ord_o    <= ord_i;
      base_o   <= col_i;
      beat_o   <= '0;
      mask_o   <= mask_i;
    end else if (active_o) begin
      if (term_i || last_o) active_o <= 1'b0;
      else                  beat_o   <= beat_o + 1'b1;
    end
  end
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           ord_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] offs;

  assign offs = (ord_i == ORD_ILV) ? (base_i ^ beat_i) : (base_i + beat_i);

  // bits under the mask walk, bits above it hold the block
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = mask_i[i] ? offs[i] : base_i[i];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       blen_i,
  input  logic             btype_i,
  input  logic             wr_single_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic             dec_legal;
  logic             dec_page;
  order_e           dec_ord;
  logic [COL_W-1:0] dec_mask;

  logic             page_q;
  order_e           ord_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;

  colgen_decode #(.COL_W(COL_W)) u_dec (
    .blen_i   (blen_i),
    .btype_i  (btype_i),
    .single_i (is_write_i && wr_single_i),
    .legal_o  (dec_legal),
    .page_o   (dec_page),
    .ord_o    (dec_ord),
    .mask_o   (dec_mask)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .term_i   (term_i),
    .legal_i  (dec_legal),
    .page_i   (dec_page),
    .ord_i    (dec_ord),
    .mask_i   (dec_mask),
    .col_i    (col_i),
    .active_o (valid_o),
    .last_o   (last_o),
    .err_o    (err_o),
    .page_o   (page_q),
    .ord_o    (ord_q),
    .base_o   (base_q),
    .beat_o   (beat_q),
    .mask_o   (mask_q)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_q),
    .ord_i  (ord_q),
    .col_o  (col_o)
  );
endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             term_i,
  input logic             valid_o,
  input logic             last_o,
  input logic             err_o,
  input logic [COL_W-1:0] col_o,
  input logic [COL_W-1:0] blk_mask
);
  // R5
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R9
  err_no_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);

  // R2
  beat_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !term_i |=> valid_o);

  // R5
  stop_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  // R7
  term_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && term_i && !start_i |=> !valid_o);

  // R3
  stay_in_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o && !start_i && !term_i |=>
      ((col_o & ~blk_mask) == ($past(col_o) & ~blk_mask)));

  // R2
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o);
endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .term_i   (term_i),
  .valid_o  (valid_o),
  .last_o   (last_o),
  .err_o    (err_o),
  .col_o    (col_o),
  .blk_mask (mask_q)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       term_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic [7:0] col_i = '0;
  logic [2:0] blen_i = '0;
  logic       btype_i = 1'b0;
  logic       wr_single_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;
  logic       err_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sdram_burst_colgen uut (
    .clk_i, .rst_ni, .start_i, .term_i, .is_write_i, .col_i,
    .blen_i, .btype_i, .wr_single_i, .col_o, .valid_o, .last_o, .err_o
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int k, int len, bit ilv);
    int blk = (base / len) * len;
    int off = base % len;
    return ilv ? blk + (off ^ k) : blk + ((off + k) % len);
  endfunction

  // at a falling edge: drive a start, return at the next falling edge (beat 0)
  task automatic pulse_start(int col, logic [2:0] bl, bit bt, bit wr, bit ws);
    col_i = col[7:0]; blen_i = bl; btype_i = bt; is_write_i = wr; wr_single_i = ws;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic burst_check(string req, int col, logic [2:0] bl, bit bt,
                             bit wr, bit ws, int len, bit ilv);
    pulse_start(col, bl, bt, wr, ws);
    for (int k = 0; k < len; k++) begin
      chk({req, " valid"}, valid_o, 1);
      chk({req, " col"}, col_o, exp_col(col, k, len, ilv));
      chk({"R5 last ", req}, last_o, (k == len - 1));
      @(negedge clk_i);
    end
    chk("R5 valid after last", valid_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_seq;
    burst_check("R2 R3 len8", 6, 3'b011, 0, 0, 0, 8, 0);
    burst_check("R3 len4", 8'h2D, 3'b010, 0, 0, 0, 4, 0);
    burst_check("R3 len2", 8'h81, 3'b001, 0, 0, 0, 2, 0);
  endtask

  task automatic t_ilv;
    burst_check("R4 len8", 5, 3'b011, 1, 0, 0, 8, 1);
    burst_check("R4 len4", 8'h16, 3'b010, 1, 0, 0, 4, 1);
  endtask

  task automatic t_single;
    burst_check("R6 len1 type ignored", 8'h9A, 3'b000, 1, 0, 0, 1, 0);
  endtask

  task automatic t_wr_single;
    burst_check("R8 write single", 8'h33, 3'b011, 0, 1, 1, 1, 0);
    burst_check("R8 read full len", 8'h33, 3'b011, 0, 0, 1, 8, 0);
  endtask

  task automatic t_page;
    int bad = 0;
    pulse_start(250, 3'b111, 0, 0, 0);
    for (int k = 0; k < 300; k++) begin
      if (!valid_o || last_o || col_o != 8'((250 + k) % 256)) bad++;
      if (k == 299) term_i = 1'b1;
      @(negedge clk_i);
    end
    term_i = 1'b0;
    chk("R7 page beats mismatched", bad, 0);
    chk("R7 valid after term", valid_o, 0);
  endtask

  task automatic t_err;
    logic [2:0] codes [5] = '{3'b100, 3'b101, 3'b110, 3'b001, 3'b111};
    bit         types [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    for (int i = 0; i < 5; i++) begin
      pulse_start(8'h10, codes[i], types[i], 0, 0);
      chk("R9 err set", err_o, 1);
      chk("R9 no beat", valid_o, 0);
      @(negedge clk_i);
      chk("R9 still no beat", valid_o, 0);
    end
    pulse_start(8'h20, 3'b000, 0, 0, 0);
    chk("R9 err cleared", err_o, 0);
    chk("R9 legal beat", valid_o, 1);
    @(negedge clk_i);
  endtask

  task automatic t_restart;
    pulse_start(0, 3'b011, 0, 0, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 pre col", col_o, 2);
    term_i = 1'b1;
    pulse_start(8'h42, 3'b010, 0, 0, 0);
    term_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R10 restart col", col_o, exp_col(8'h42, k, 4, 0));
      chk("R10 restart valid", valid_o, 1);
      @(negedge clk_i);
    end
    chk("R10 end", valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_seq();
    t_ilv();
    t_single();
    t_wr_single();
    t_page();
    t_err();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule